// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets a host reach the management registers of an Ethernet PHY through a two-wire serial management interface (MDC clock, MDIO data). The host sees one 32-bit command/status word. Writing that word starts a management frame. Bit 26 selects a read or a write, and the word also carries the PHY address, the register address and, for a write, the 16-bit data. While the frame is being shifted out, a busy flag is set in the same word. When a read completes, the PHY's 16-bit answer replaces the low half of the word and a read-valid flag is raised.

The block contains the MDC divider, the frame sequencer and shifter, and the output-enable control for the shared MDIO pin. The pin is presented as separate output, output-enable and input signals, so that a pad cell can combine them. The number of preamble ones is a parameter. Frames use the two-bit-start, five-bit-address management format. The host is expected to poll busy before issuing a command and to poll read-valid after issuing a read.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the status word reads 0, MDC is low and the MDIO output enable is low.
- R2: A write command (bit 26 = 0) produces a frame in which every bit is driven. The frame is PRE_LEN ones, then 01, then opcode 01, then the PHY address (bits 20:16), then the register address (bits 25:21), then turnaround 10, then data bits 15:0. Every field is sent MSB first.
- R3: A read command (bit 26 = 1) sends the PRE_LEN ones, then 01, then opcode 10, then both addresses and a driven first turnaround bit of 1. The output enable is then low from the second turnaround bit through the last data bit.
- R4: During a read, MDIO is sampled on each of the 16 rising MDC edges of the data phase, MSB first. At the end of the frame the value is placed in bits 15:0 and bit 27 (read-valid) becomes 1.
- R5: Bit 28 (busy) reads 1 from the cycle after an accepted command write until the frame's last MDC falling edge. Outside that window it reads 0.
- R6: A command write while busy is 1 is ignored. The word's fields and the frame in progress are unchanged.
- R7: Every accepted command write clears read-valid. Otherwise read-valid holds its value.
- R8: During a frame, MDC has a period of CLK_DIV system clocks with equal high and low times. When no frame is active, MDC stays low and the output enable stays low.
- R9: Bits 25:16 of the status word read back the addresses of the last accepted command, and bit 26 reads back its opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 32 | Command word written by the host |
| cmd_rdata | output | 32 | Command/status word read by the host |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench acts as the PHY. It records MDIO and the output enable on every rising MDC edge and returns data that includes all-ones and single-LSB patterns. A design that released the pin one bit early or late would show the wrong enable pattern at the turnaround. A design that sampled on the falling edge, or in the wrong bit order, would return shifted or reversed read data. A second command is thrown at the block in the middle of a frame: a block that accepted it would corrupt the fields or the frame on the wire. The bench also checks that read-valid survives idle time and is cleared by the next command. It measures the MDC period and duty cycle, which exposes any divider that counts one cycle off.

// File: rtl/mdio_ctrl_pkg.sv
package mdio_ctrl_pkg;

  // Host word layout (low 27 bits map onto mdio_cmd_t)
  localparam int RVALID_BIT = 27;
  localparam int BUSY_BIT   = 28;

  // Frame body after the preamble: start(2) op(2) phy(5) reg(5) ta(2) data(16)
  localparam int BODY_BITS = 32;
  localparam int TA_OFS    = 14;
  localparam int DATA_OFS  = 16;

  typedef struct packed {
    logic       rd;
    logic [4:0] regad;
    logic [4:0] phy;
    logic [15:0] data;
  } mdio_cmd_t;

  // Serial body for a command, MSB sent first.
  function automatic logic [BODY_BITS-1:0] frame_body(mdio_cmd_t c);
    logic [1:0] op;
    logic [1:0] ta;
    logic [15:0] dat;
    op  = c.rd ? 2'b10 : 2'b01;
    ta  = c.rd ? 2'b11 : 2'b10;
    dat = c.rd ? 16'h0000 : c.data;
    return {2'b01, op, c.phy, c.regad, ta, dat};
  endfunction

  // Frame bit index where a read stops driving MDIO.
  function automatic int release_idx(int pre_len);
    return pre_len + TA_OFS + 1;
  endfunction

  // Frame bit index of the first read data bit.
  function automatic int data_idx(int pre_len);
    return pre_len + DATA_OFS;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == CW'(HALF - 1));
  assign rise_tk = en && wrap && !mdc;
  assign fall_tk = en && wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  p_tick_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_tk, fall_tk}));

  p_mdc_low_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_ctrl_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_tk,
  input  logic        fall_tk,
  input  logic        mdio_i,
  output logic        run,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rd_data
);
  localparam int TOTAL  = PRE_LEN + BODY_BITS;
  localparam int IW     = $clog2(TOTAL);
  localparam int REL    = release_idx(PRE_LEN);
  localparam int DSTART = data_idx(PRE_LEN);

  logic                 rd_q;
  logic [IW-1:0]        idx;
  logic [BODY_BITS-1:0] sh;
  logic [15:0]          rsh;
  logic                 last_bit;
  logic                 in_body;
  logic                 in_rdata;
  logic                 released;

  assign last_bit = (idx == IW'(TOTAL - 1));
  assign in_body  = (idx >= IW'(PRE_LEN));
  assign in_rdata = rd_q && (idx >= IW'(DSTART));
  assign released = rd_q && (idx >= IW'(REL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      rd_q <= 1'b0;
      idx  <= '0;
      sh   <= '0;
      rsh  <= '0;
    end else if (start) begin
      run  <= 1'b1;
      rd_q <= cmd.rd;
      idx  <= '0;
      sh   <= frame_body(cmd);
      rsh  <= '0;
    end else if (run) begin
      if (rise_tk && in_rdata)
        rsh <= {rsh[14:0], mdio_i};
      if (fall_tk) begin
        if (last_bit) begin
          run <= 1'b0;
        end else begin
          idx <= idx + IW'(1);
          if (in_body)
            sh <= {sh[BODY_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign mdio_o  = (run && in_body) ? sh[BODY_BITS-1] : 1'b1;
  assign mdio_oe = run && !released;
  assign done    = run && fall_tk && last_bit;
  assign rd_data = rsh;

  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (idx < IW'(TOTAL)) || (TOTAL == (1 << IW)));

  p_release_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mdio_oe) |-> rd_q);

  p_sample_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_tk && !start) |=> $stable(rsh));

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_ctrl_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t   wcmd;
  mdio_cmd_t   cmd_q;
  logic        busy_q;
  logic        rvalid_q;
  logic        accept;
  logic        sh_run;
  logic        sh_done;
  logic        rise_tk;
  logic        fall_tk;
  logic [15:0] rd_data;

  assign wcmd   = mdio_cmd_t'(cmd_wdata[26:0]);
  assign accept = cmd_wr && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      busy_q   <= 1'b0;
      rvalid_q <= 1'b0;
    end else if (accept) begin
      cmd_q    <= wcmd;
      busy_q   <= 1'b1;
      rvalid_q <= 1'b0;
    end else if (sh_done) begin
      busy_q <= 1'b0;
      if (cmd_q.rd) begin
        cmd_q.data <= rd_data;
        rvalid_q   <= 1'b1;
      end
    end
  end

  assign cmd_rdata = {3'b000, busy_q, rvalid_q, cmd_q};

  mdio_mdc_gen #(.DIV(CLK_DIV)) u_mdc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (sh_run),
    .mdc     (mdc),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  mdio_frame_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .cmd     (wcmd),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk),
    .mdio_i  (mdio_i),
    .run     (sh_run),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (sh_done),
    .rd_data (rd_data)
  );

  p_busy_tracks_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q == sh_run);

  p_mdc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc);

  p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe);

  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_wr && !sh_done) |=> $stable(cmd_rdata[26:0]));

  p_rvalid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rdata[BUSY_BIT]) |=> (cmd_rdata[BUSY_BIT] && !cmd_rdata[RVALID_BIT]));

  p_rvalid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_q && !cmd_wr) |=> rvalid_q);

  p_rvalid_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid_q) |-> ($fell(busy_q) && cmd_q.rd));

endmodule

// File: tb/tb_mdio_cmd_ctrl.sv
module tb_mdio_cmd_ctrl;
  localparam int DIV = 4;
  localparam int PRE = 32;
  localparam int FB  = PRE + 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_cmd_ctrl #(.CLK_DIV(DIV), .PRE_LEN(PRE)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    bit         rd;
    logic [4:0] phy;
    logic [4:0] ra;
    logic [15:0] data;
  } exp_t;
  exp_t q[$];

  // PHY model
  logic [FB-1:0] cap_o, cap_oe;
  int            fr_cnt = 0;
  logic [15:0]   phy_ret = '0;
  time           t_rise_prev = 0;
  time           period = 0;
  time           t_hi = 0;

  always @(posedge mdc) begin
    if (fr_cnt < FB) begin
      cap_o[FB-1-fr_cnt]  = mdio_o;
      cap_oe[FB-1-fr_cnt] = mdio_oe;
    end
    fr_cnt++;
    if (t_rise_prev != 0) period = $time - t_rise_prev;
    t_rise_prev = $time;
  end

  always @(negedge mdc) begin
    t_hi = $time - t_rise_prev;
    if (fr_cnt >= PRE + 16 && fr_cnt < PRE + 32)
      mdio_i = phy_ret[15 - (fr_cnt - PRE - 16)];
    else
      mdio_i = 1'b1;
  end

  // Monitor: compare each finished frame against the scoreboard
  logic busy_prev = 1'b0;
  always @(negedge clk) begin
    exp_t e;
    logic [FB-1:0] ef, eoe;
    if (rst_n && busy_prev && !cmd_rdata[28]) begin
      if (q.size() == 0) begin
        check(1'b0, "R5", "frame end with empty queue", 1, 0);
      end else begin
        e  = q.pop_front();
        ef = {{PRE{1'b1}}, 2'b01, (e.rd ? 2'b10 : 2'b01), e.phy, e.ra,
              (e.rd ? 2'b11 : 2'b10), (e.rd ? 16'h0 : e.data)};
        for (int k = 0; k < FB; k++)
          eoe[FB-1-k] = !e.rd || (k < PRE + 15);
        check(fr_cnt == FB, "R2", "MDC rising edges per frame", fr_cnt, FB);
        check(cap_oe == eoe, e.rd ? "R3" : "R2", "output enable pattern", cap_oe, eoe);
        check((cap_o & eoe) == (ef & eoe), e.rd ? "R3" : "R2", "frame bits",
              cap_o & eoe, ef & eoe);
        check(period == DIV * 10, "R8", "MDC period ns", period, DIV * 10);
        check(t_hi == DIV * 5, "R8", "MDC high time ns", t_hi, DIV * 5);
        check(cmd_rdata[25:16] == {e.ra, e.phy}, "R9", "address readback",
              cmd_rdata[25:16], {e.ra, e.phy});
        check(cmd_rdata[26] == e.rd, "R9", "opcode readback", cmd_rdata[26], e.rd);
        if (e.rd) begin
          check(cmd_rdata[15:0] == e.data, "R4", "read data", cmd_rdata[15:0], e.data);
          check(cmd_rdata[27] == 1'b1, "R4", "read-valid set", cmd_rdata[27], 1);
        end else begin
          check(cmd_rdata[27] == 1'b0, "R7", "read-valid after write", cmd_rdata[27], 0);
        end
      end
    end
    busy_prev = cmd_rdata[28];
  end

  // Driver: wait idle, push expectation, issue one command
  task automatic issue(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] data, input logic [15:0] ret);
    exp_t e;
    do @(negedge clk); while (cmd_rdata[28]);
    @(negedge clk);
    phy_ret     = ret;
    fr_cnt      = 0;
    t_rise_prev = 0;
    e.rd = rd; e.phy = phy; e.ra = ra; e.data = rd ? ret : data;
    q.push_back(e);
    cmd_wdata = {5'b0, rd, ra, phy, data};
    cmd_wr    = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata[28] == 1'b1, "R5", "busy after accepted write", cmd_rdata[28], 1);
    check(cmd_rdata[27] == 1'b0, "R7", "read-valid cleared by new command", cmd_rdata[27], 0);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (cmd_rdata[28]);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cmd_rdata == 32'h0, "R1", "status word in reset", cmd_rdata, 0);
    check(mdc == 1'b0, "R1", "mdc in reset", mdc, 0);
    check(mdio_oe == 1'b0, "R1", "oe in reset", mdio_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_rdata[28] == 1'b0, "R5", "idle not busy", cmd_rdata[28], 0);

    issue(1'b0, 5'd5, 5'h1A, 16'hA55A, 16'h0);
    issue(1'b1, 5'h11, 5'd3, 16'h0, 16'h1234);
    wait_idle();
    repeat (20) @(negedge clk);
    check(cmd_rdata[27] == 1'b1, "R7", "read-valid held while idle", cmd_rdata[27], 1);
    check(cmd_rdata[15:0] == 16'h1234, "R4", "read data held", cmd_rdata[15:0], 16'h1234);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R8", "idle mdc/oe", {mdc, mdio_oe}, 0);

    issue(1'b0, 5'd0, 5'd31, 16'h8001, 16'h0);
    issue(1'b1, 5'd31, 5'd31, 16'h0, 16'hFFFF);
    issue(1'b1, 5'd0, 5'd0, 16'hBEEF, 16'h0001);
    issue(1'b1, 5'h0A, 5'h15, 16'h0, 16'h8000);

    // R6: a command write during a frame is ignored
    issue(1'b0, 5'd2, 5'd4, 16'h0F0F, 16'h0);
    repeat (10) @(negedge clk);
    snap = cmd_rdata;
    cmd_wdata = {5'b0, 1'b1, 5'd9, 5'd7, 16'h1111};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata == snap, "R6", "fields unchanged by write while busy", cmd_rdata, snap);
    wait_idle();
    check(q.size() == 0, "R6", "no extra frame from ignored write", q.size(), 0);
    check(cmd_rdata[25:16] == {5'd4, 5'd2}, "R6", "addresses kept", cmd_rdata[25:16],
          {5'd4, 5'd2});

    repeat (10) @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R8", "idle at end", {mdc, mdio_oe}, 0);
    finish_run();
  end

endmodule